// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block is the command-level controller for a serial flash auto-increment programming mode. A host opens the mode with one long frame (opcode ADh, a start address of three bytes sent most significant byte first, then two data bytes). It keeps writing with short frames that hold only the opcode and two data bytes, so the address is never sent again. Every accepted frame becomes a single word-write request to the memory array. A program timer then holds the block busy for a set number of cycles per word.

The block receives bytes from a serial shifter as a chip-enable level and a byte strobe. It reads the write-enable latch and the protection setting as flags, and it pulses a latch-clear request back to the status storage. While the mode runs, only a short list of opcodes is legal, and any other opcode is flagged at once. When the hardware completion mode is on, the serial output pin reports ready/busy as soon as chip enable goes active.

Top module: `aaiSeq`

## Requirements
- R1: After reset the mode flag, hardware-report flag, busy, write request, latch-clear pulse and SO output enable are all 0.
- R2: An entry frame (ADh, three address bytes MSB first, data byte 0, data byte 1) that arrives while the block is idle, with welIn=1 and an unprotected start word, gives one wrReq pulse in the cycle after chip enable is released. That pulse carries wrAddr = start address with bit 0 cleared and wrData = {data1, data0}, so data0 is in bits [7:0] and goes to the even byte. The mode flag is set in the same cycle.
- R3: While the mode is active, a continuation frame (ADh, data0, data1) writes to the word address two above the previous write.
- R4: An entry frame is ignored (no write, mode flag stays 0) when welIn=0 or when the odd byte of the start word lies above the highest unprotected address.
- R5: Each write holds busy at 1 for exactly PROG_CYCLES cycles, starting with the cycle of wrReq. An ADh frame that ends while busy=1 writes nothing and leaves the write pointer unchanged.
- R6: A frame that ends before both data bytes have arrived is discarded: no write and no change of mode.
- R7: While the mode is active, a first frame byte outside the legal set raises opReject for one cycle, in the cycle after that byte. The legal set is ADh, 04h and 05h with hwMode=0, and ADh and 04h with hwMode=1.
- R8: A one-byte frame 70h sets hwMode and a one-byte frame 80h clears it, but only while the mode is inactive. While the mode is active both are ignored.
- R9: soOe is high exactly when chip enable is active, hwMode=1 and the mode is active. It follows chip enable with no register delay. soValue is 0 while busy and 1 when ready.
- R10: A one-byte frame 04h clears the mode flag and pulses welClr for one cycle.
- R11: A write whose odd byte address reaches the highest unprotected address (protBase-1 when protEn=1, otherwise all ones) ends the mode and pulses welClr in the cycle of that wrReq. The address never wraps.
- R12: Frames with other opcodes, and rejected opcodes, leave the mode flag and the write pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csActive | input | 1 | Chip enable asserted (frame in progress) |
| byteValid | input | 1 | One-cycle strobe: byteData holds a received byte |
| byteData | input | 8 | Received byte |
| welIn | input | 1 | Write-enable latch value from status storage |
| protEn | input | 1 | Upper-region protection enabled |
| protBase | input | 24 | First protected address when protEn=1 |
| wrReq | output | 1 | One-cycle word-write request to the array |
| wrAddr | output | 24 | Even byte address of the word being written |
| wrData | output | 16 | {odd byte, even byte} |
| busy | output | 1 | Internal program in progress |
| aaiActive | output | 1 | Auto-increment mode flag |
| hwMode | output | 1 | Ready/busy reporting on SO enabled |
| welClr | output | 1 | One-cycle request to clear the write-enable latch |
| opReject | output | 1 | Illegal opcode seen while the mode is active |
| soOe | output | 1 | SO drive enable (0 means high impedance) |
| soValue | output | 1 | SO level when driven: 1 ready, 0 busy |

## Verification
A final-word write and the exit from the mode happen in the same cycle: one wrReq pulse must coincide with the fall of the mode flag and a welClr pulse. The bench provokes this by narrowing the protection limit so that the second word of a run ends on the highest unprotected address. It also places an entry frame on the top word of the address space. In both cases it checks the written address, the flag and the pulse in the same sampled cycle, and then confirms that a further ADh frame produces no write. A second overlap, a new frame ending while the timer still runs, is provoked by sending a continuation right after a write. The check is that no request appears and that the following accepted frame lands on the untouched next address.

// File: rtl/aaiPkg.sv
package aaiPkg;

  localparam logic [7:0] OP_AAI_WORD = 8'hAD;
  localparam logic [7:0] OP_WR_DIS   = 8'h04;
  localparam logic [7:0] OP_STAT_RD  = 8'h05;
  localparam logic [7:0] OP_HW_ON    = 8'h70;
  localparam logic [7:0] OP_HW_OFF   = 8'h80;

  // strobes from control to datapath
  typedef struct packed {
    logic contFrame;   // mode active: frames carry no address
    logic issueWrite;  // launch one word write at the current target
  } ctrlStrobe_t;

  // frame and pointer status from datapath to control
  typedef struct packed {
    logic [7:0] opcode;
    logic       atFirst;    // next byte is the opcode
    logic       opOnly;     // exactly one byte in the frame
    logic       entryFull;  // entry frame has both data bytes
    logic       contFull;   // continuation frame has both data bytes
    logic       entryOk;    // start word is unprotected
    logic       lastWord;   // target word reaches the limit
    logic       busy;
  } dpStatus_t;

  function automatic logic opLegal(input logic [7:0] op, input logic hw);
    logic ok;
    ok = (op == OP_AAI_WORD) || (op == OP_WR_DIS);
    if (!hw && op == OP_STAT_RD) ok = 1'b1;
    return ok;
  endfunction

endpackage

// File: rtl/aaiDatapath.sv
module aaiDatapath
  import aaiPkg::*;
#(
  parameter int AW          = 24,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              protEn,
  input  logic [AW-1:0]     protBase,
  input  ctrlStrobe_t       ctrl,
  output dpStatus_t         stat,
  output logic              wrReq,
  output logic [AW-1:0]     wrAddr,
  output logic [15:0]       wrData
);

  localparam int ADDR_BYTES = (AW + 7) / 8;
  localparam int CAW        = ADDR_BYTES * 8;
  localparam int ENTRY_LEN  = 1 + ADDR_BYTES + 2;
  localparam int CW         = $clog2(ENTRY_LEN + 1);
  localparam int TW         = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [TW-1:0] TLOAD    = TW'(PROG_CYCLES);
  localparam logic [AW-1:0] ALL_ONES = '1;
  localparam logic [AW-1:0] ONE      = AW'(1);
  localparam logic [AW-1:0] TWO      = AW'(2);

  logic [CW-1:0]  byteCnt;
  logic [7:0]     opcode;
  logic [CAW-1:0] capAddr;
  logic [7:0]     dataLo, dataHi;
  logic [AW-1:0]  wordPtr;
  logic [TW-1:0]  timer;

  logic [AW-1:0]  limitAddr, alignedCap, tgtAddr;
  logic           allProt;

  // byte capture: opcode, address bytes (entry only), data pair
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      opcode  <= '0;
      capAddr <= '0;
      dataLo  <= '0;
      dataHi  <= '0;
    end else if (!csActive) begin
      byteCnt <= '0;
    end else if (byteValid) begin
      if (byteCnt != CNT_MAX) byteCnt <= byteCnt + CW'(1);
      if (byteCnt == '0) begin
        opcode <= byteData;
      end else if (!ctrl.contFrame) begin
        if (byteCnt <= CW'(ADDR_BYTES))
          capAddr <= {capAddr[CAW-9:0], byteData};
        else if (byteCnt == CW'(ADDR_BYTES + 1))
          dataLo <= byteData;
        else if (byteCnt == CW'(ADDR_BYTES + 2))
          dataHi <= byteData;
      end else begin
        if (byteCnt == CW'(1))
          dataLo <= byteData;
        else if (byteCnt == CW'(2))
          dataHi <= byteData;
      end
    end
  end

  // protection limit and target word
  always_comb begin
    allProt    = protEn && (protBase == '0);
    limitAddr  = protEn ? (protBase - ONE) : ALL_ONES;
    alignedCap = capAddr[AW-1:0] & ~ONE;
    tgtAddr    = ctrl.contFrame ? wordPtr : alignedCap;
  end

  always_comb begin
    stat.opcode    = opcode;
    stat.atFirst   = (byteCnt == '0);
    stat.opOnly    = (byteCnt == CW'(1));
    stat.entryFull = (byteCnt >= CW'(ENTRY_LEN));
    stat.contFull  = (byteCnt >= CW'(3));
    stat.entryOk   = !allProt && ((alignedCap | ONE) <= limitAddr);
    stat.lastWord  = ((tgtAddr | ONE) >= limitAddr);
    stat.busy      = (timer != '0);
  end

  // write launch, pointer advance and program timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrReq   <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
      wordPtr <= '0;
      timer   <= '0;
    end else begin
      wrReq <= ctrl.issueWrite;
      if (ctrl.issueWrite) begin
        wrAddr  <= tgtAddr;
        wrData  <= {dataHi, dataLo};
        wordPtr <= tgtAddr + TWO;
        timer   <= TLOAD;
      end else if (timer != '0) begin
        timer <= timer - TW'(1);
      end
    end
  end

  AST_WRITE_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> !wrAddr[0]);  // R2
  AST_WRITE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> stat.busy);  // R5
  AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.issueWrite |=> $stable(wordPtr));  // R12

endmodule

// File: rtl/aaiControl.sv
module aaiControl
  import aaiPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csActive,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        welIn,
  input  dpStatus_t   stat,
  output ctrlStrobe_t ctrl,
  output logic        aaiActive,
  output logic        hwMode,
  output logic        welClr,
  output logic        opReject
);

  logic csPrev;
  logic frameEnd;
  logic issue;
  logic aaiNext, hwNext, welClrNext;

  assign frameEnd = csPrev && !csActive;

  always_comb begin
    issue      = 1'b0;
    aaiNext    = aaiActive;
    hwNext     = hwMode;
    welClrNext = 1'b0;
    if (frameEnd) begin
      unique case (stat.opcode)
        OP_AAI_WORD: begin
          if (!stat.busy) begin
            if (!aaiActive)
              issue = welIn && stat.entryFull && stat.entryOk;
            else
              issue = stat.contFull;
          end
          if (issue) begin
            aaiNext    = !stat.lastWord;
            welClrNext = stat.lastWord;
          end
        end
        OP_WR_DIS: begin
          if (stat.opOnly) begin
            aaiNext    = 1'b0;
            welClrNext = 1'b1;
          end
        end
        OP_HW_ON:  if (stat.opOnly && !aaiActive) hwNext = 1'b1;
        OP_HW_OFF: if (stat.opOnly && !aaiActive) hwNext = 1'b0;
        default: ;
      endcase
    end
  end

  assign ctrl.contFrame  = aaiActive;
  assign ctrl.issueWrite = issue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev    <= 1'b0;
      aaiActive <= 1'b0;
      hwMode    <= 1'b0;
      welClr    <= 1'b0;
      opReject  <= 1'b0;
    end else begin
      csPrev    <= csActive;
      aaiActive <= aaiNext;
      hwMode    <= hwNext;
      welClr    <= welClrNext;
      opReject  <= byteValid && csActive && stat.atFirst && aaiActive
                   && !opLegal(byteData, hwMode);
    end
  end

  AST_ENTRY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aaiActive) |-> $past(welIn));  // R4
  AST_EXIT_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aaiActive) |-> welClr);  // R10
  AST_HW_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    aaiActive |=> hwMode == $past(hwMode));  // R8
  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.issueWrite |-> !stat.busy);  // R5

endmodule

// File: rtl/aaiSeq.sv
module aaiSeq
  import aaiPkg::*;
#(
  parameter int AW          = 24,
  parameter int PROG_CYCLES = 200
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csActive,
  input  logic          byteValid,
  input  logic [7:0]    byteData,
  input  logic          welIn,
  input  logic          protEn,
  input  logic [AW-1:0] protBase,
  output logic          wrReq,
  output logic [AW-1:0] wrAddr,
  output logic [15:0]   wrData,
  output logic          busy,
  output logic          aaiActive,
  output logic          hwMode,
  output logic          welClr,
  output logic          opReject,
  output logic          soOe,
  output logic          soValue
);

  ctrlStrobe_t ctrl;
  dpStatus_t   stat;

  aaiDatapath #(.AW(AW), .PROG_CYCLES(PROG_CYCLES)) i_dp (
    .clk(clk), .rstN(rstN), .csActive(csActive), .byteValid(byteValid),
    .byteData(byteData), .protEn(protEn), .protBase(protBase),
    .ctrl(ctrl), .stat(stat), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData)
  );

  aaiControl i_ctl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .byteValid(byteValid),
    .byteData(byteData), .welIn(welIn), .stat(stat), .ctrl(ctrl),
    .aaiActive(aaiActive), .hwMode(hwMode), .welClr(welClr),
    .opReject(opReject)
  );

  assign busy    = stat.busy;
  assign soOe    = csActive && hwMode && aaiActive;
  assign soValue = !stat.busy;

  AST_SO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !aaiActive |-> !soOe);  // R9

endmodule

// File: tb/test_aaiSeq.sv
module test_aaiSeq;

  localparam int PROG = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csActive = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        welIn = 1'b0;
  logic        protEn = 1'b0;
  logic [23:0] protBase = '0;
  logic        wrReq, busy, aaiActive, hwMode, welClr, opReject, soOe, soValue;
  logic [23:0] wrAddr;
  logic [15:0] wrData;

  aaiSeq #(.AW(24), .PROG_CYCLES(PROG)) i_aaiSeq (
    .clk(clk), .rstN(rstN), .csActive(csActive), .byteValid(byteValid),
    .byteData(byteData), .welIn(welIn), .protEn(protEn), .protBase(protBase),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .busy(busy),
    .aaiActive(aaiActive), .hwMode(hwMode), .welClr(welClr),
    .opReject(opReject), .soOe(soOe), .soValue(soValue)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  logic [7:0]  fb [0:7];
  logic        firstRej;
  logic        gotWr, gotWel;
  logic [23:0] gotAddr;
  logic [15:0] gotData;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks = nChecks + 1;
    if (act !== exp) begin
      nFail = nFail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input logic [7:0] d0, input logic [7:0] d1);
    return {d1, d0};
  endfunction

  function automatic logic [23:0] expAlign(input logic [23:0] a);
    return {a[23:1], 1'b0};
  endfunction

  task automatic runFrame(input int n);
    @(negedge clk) csActive = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b1;
      byteData  = fb[i];
      @(negedge clk);
      byteValid = 1'b0;
      if (i == 0) firstRej = opReject;
    end
    @(negedge clk) csActive = 1'b0;
    @(negedge clk);
    gotWr   = wrReq;
    gotWel  = welClr;
    gotAddr = wrAddr;
    gotData = wrData;
  endtask

  task automatic entry(input logic [23:0] a, input logic [7:0] d0, input logic [7:0] d1, input int n);
    fb[0] = 8'hAD; fb[1] = a[23:16]; fb[2] = a[15:8]; fb[3] = a[7:0];
    fb[4] = d0; fb[5] = d1;
    runFrame(n);
  endtask

  task automatic cont(input logic [7:0] d0, input logic [7:0] d1, input int n);
    fb[0] = 8'hAD; fb[1] = d0; fb[2] = d1;
    runFrame(n);
  endtask

  task automatic single(input logic [7:0] op);
    fb[0] = op;
    runFrame(1);
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int cnt;
    logic [23:0] ptr;
    logic [7:0] r0, r1;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 aaiActive", 32'(aaiActive), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 wrReq", 32'(wrReq), 0);
    check("R1 hwMode", 32'(hwMode), 0);
    check("R1 welClr", 32'(welClr), 0);
    check("R1 soOe", 32'(soOe), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 latch not set
    entry(24'h001000, 8'h11, 8'h22, 6);
    check("R4 no write without latch", 32'(gotWr), 0);
    check("R4 mode stays off", 32'(aaiActive), 0);

    // R4 protected start
    welIn = 1'b1; protEn = 1'b1; protBase = 24'h000010;
    entry(24'h000012, 8'h11, 8'h22, 6);
    check("R4 protected start ignored", 32'(gotWr), 0);
    protEn = 1'b0;

    // R6 short entry
    entry(24'h003000, 8'h11, 8'h22, 5);
    check("R6 short entry no write", 32'(gotWr), 0);
    check("R6 short entry no mode", 32'(aaiActive), 0);

    // R2 entry, odd start address
    entry(24'h001001, 8'hA5, 8'h5A, 6);
    check("R2 write", 32'(gotWr), 1);
    check("R2 addr", 32'(gotAddr), 32'(expAlign(24'h001001)));
    check("R2 data", 32'(gotData), 32'(expWord(8'hA5, 8'h5A)));
    check("R2 mode set", 32'(aaiActive), 1);
    waitIdle(cnt);
    check("R5 busy length", 32'(cnt), PROG);

    // R5 frame while busy, R3 continuation
    cont(8'h01, 8'h02, 3);
    check("R3 cont write", 32'(gotWr), 1);
    check("R3 cont addr", 32'(gotAddr), 32'h001002);
    cont(8'h03, 8'h04, 3);
    check("R5 busy frame ignored", 32'(gotWr), 0);
    waitIdle(cnt);
    cont(8'h05, 8'h06, 3);
    check("R5 pointer unchanged", 32'(gotAddr), 32'h001004);
    check("R3 data", 32'(gotData), 32'(expWord(8'h05, 8'h06)));
    waitIdle(cnt);

    // R6 short continuation
    cont(8'h07, 8'h08, 2);
    check("R6 short cont no write", 32'(gotWr), 0);
    cont(8'h09, 8'h0A, 3);
    check("R6 next cont addr", 32'(gotAddr), 32'h001006);
    waitIdle(cnt);

    // R7 / R12 whitelist in software mode
    single(8'h05);
    check("R7 status read legal", 32'(firstRej), 0);
    single(8'h03);
    check("R7 read rejected", 32'(firstRej), 1);
    single(8'h20);
    check("R7 erase rejected", 32'(firstRej), 1);
    check("R12 mode kept", 32'(aaiActive), 1);
    // R8 enable ignored while active
    single(8'h70);
    check("R8 hw on ignored when active", 32'(hwMode), 0);
    cont(8'h0B, 8'h0C, 3);
    check("R12 pointer kept", 32'(gotAddr), 32'h001008);
    waitIdle(cnt);

    // R10 exit
    single(8'h04);
    check("R10 mode cleared", 32'(aaiActive), 0);
    check("R10 latch clear pulse", 32'(gotWel), 1);
    @(negedge clk);
    check("R10 pulse one cycle", 32'(welClr), 0);

    // R8 / R9 hardware mode
    single(8'h70);
    check("R8 hw on", 32'(hwMode), 1);
    entry(24'h002000, 8'h33, 8'h44, 6);
    check("R2 hw entry addr", 32'(gotAddr), 32'h002000);
    csActive = 1'b1; #1;
    check("R9 so driven at cs", 32'(soOe), 1);
    check("R9 so busy", 32'(soValue), 0);
    @(negedge clk) csActive = 1'b0; #1;
    check("R9 so released", 32'(soOe), 0);
    waitIdle(cnt);
    csActive = 1'b1; #1;
    check("R9 so ready", 32'(soValue), 1);
    @(negedge clk) csActive = 1'b0;
    single(8'h05);
    check("R7 status read rejected hw", 32'(firstRej), 1);
    single(8'h80);
    check("R8 hw off ignored when active", 32'(hwMode), 1);
    single(8'h04);
    check("R7 disable legal hw", 32'(firstRej), 0);
    single(8'h80);
    check("R8 hw off", 32'(hwMode), 0);

    // R11 limit from protection
    protEn = 1'b1; protBase = 24'h000010;
    entry(24'h00000C, 8'h55, 8'h66, 6);
    check("R11 first word", 32'(gotAddr), 32'h00000C);
    waitIdle(cnt);
    cont(8'h77, 8'h88, 3);
    check("R11 last word addr", 32'(gotAddr), 32'h00000E);
    check("R11 last word write", 32'(gotWr), 1);
    check("R11 latch clear", 32'(gotWel), 1);
    check("R11 mode ended", 32'(aaiActive), 0);
    waitIdle(cnt);
    cont(8'h99, 8'hAA, 3);
    check("R11 no wrap write", 32'(gotWr), 0);
    protEn = 1'b0;

    // R11 top of address space
    entry(24'hFFFFFE, 8'hBB, 8'hCC, 6);
    check("R11 top addr", 32'(gotAddr), 32'hFFFFFE);
    check("R11 top ends mode", 32'(aaiActive), 0);
    check("R11 top latch clear", 32'(gotWel), 1);
    waitIdle(cnt);

    // random runs
    ptr = 24'($urandom) & 24'h7FFFF0;
    r0 = 8'($urandom); r1 = 8'($urandom);
    entry(ptr, r0, r1, 6);
    check("R2 random entry", 32'(gotAddr), 32'(ptr));
    ptr = ptr + 24'd2;
    waitIdle(cnt);
    for (int k = 0; k < 24; k++) begin
      int kind;
      kind = int'($urandom % 3);
      r0 = 8'($urandom); r1 = 8'($urandom);
      if (kind == 0) begin
        cont(r0, r1, 3);
        check("R3 random addr", 32'(gotAddr), 32'(ptr));
        check("R3 random data", 32'(gotData), 32'(expWord(r0, r1)));
        ptr = ptr + 24'd2;
        waitIdle(cnt);
      end else if (kind == 1) begin
        cont(r0, r1, 1 + int'($urandom % 2));
        check("R6 random short", 32'(gotWr), 0);
      end else begin
        cont(r0, r1, 3);
        check("R3 random write", 32'(gotWr), 1);
        ptr = ptr + 24'd2;
        cont(r1, r0, 3);
        check("R5 random busy drop", 32'(gotWr), 0);
        waitIdle(cnt);
      end
    end
    single(8'h04);
    check("R10 final exit", 32'(aaiActive), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule